// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the serial slave front end of a dual converter. A host shifts 16-bit command words in over a three-wire link (serial clock, serial data, active-low select). The receiver brings those pins into the system clock domain, samples the data line on each rising serial clock while the select is low, and hands the finished word to the command logic as a 4-bit control field and a 12-bit data field with a one-cycle valid strobe. The word is committed when the select returns high. Nothing is committed on a bit count alone.

The last stage of the shift chain drives the serial data output, and it changes on falling serial clock edges. While a new word goes in, the previous contents of the chain therefore come out, which lets several receivers be daisy-chained or a word be read back. Converters of lower resolution keep their data left-justified in the 12-bit field, and the trailing bits they do not use are forced to zero. A frame whose length is not exactly 16 bits is dropped, and an error pulse is raised instead of the strobe.

Top module: `cmdword_rx`

## Requirements
- R1: After the synchronous reset `rst`, the outputs `ctrl`, `data`, `sdo`, `word_vld` and `frame_err` are all zero.
- R2: Bits are sampled on rising `sck` edges while `cs_n` is low, most significant first. The first 4 bits become `ctrl[3:0]` (first bit in `ctrl[3]`), and the next 12 bits become `data[11:0]` (first of these in `data[11]`).
- R3: When `cs_n` rises after exactly 16 sampled bits, `ctrl` and `data` take the new word, and `word_vld` is high for exactly one clock cycle.
- R4: When `cs_n` rises after any other number of bits (fewer or more than 16), `word_vld` stays low, `ctrl` and `data` keep their old values, and `frame_err` pulses for one cycle.
- R5: While `cs_n` is high, activity on `sck` and `sdi` does not change the shift chain, the bit count or the outputs.
- R6: `sdo` shows the last stage of the 16-stage shift chain. It takes the chain MSB when `cs_n` falls and after every falling `sck` edge. During a 16-bit frame it therefore emits the chain contents from before the frame, MSB first, one bit before each rising `sck`.
- R7: With parameter `DATA_BITS` below 12, `data` carries the top `DATA_BITS` bits of the data field, and the lower `12-DATA_BITS` bits read zero (with 8, `data[3:0]` is zero).
- R8: Holding `clr_n` low clears the shift chain, `ctrl`, `data` and `sdo` to zero.
- R9: `ctrl` and `data` change only in the cycle in which `word_vld` is high, or after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the `sck` rate |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear, synchronized inside |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select that frames a word |
| sdo | output | 1 | Serial data out, last stage of the shift chain |
| ctrl | output | 4 | Control field of the last committed word |
| data | output | 12 | Left-justified data field of the last committed word |
| word_vld | output | 1 | One-cycle strobe when a word is committed |
| frame_err | output | 1 | One-cycle pulse when a frame had the wrong bit count |

## Verification
The embedded properties check the cycle-level rules at every clock. The strobe lasts a single cycle. A rejected frame leaves the held word unchanged. The shift chain does not move while the synchronized select is high. `sdo` moves only after a falling serial edge, a select fall or a clear. The outputs change only with the strobe or after a clear. Bit order, the field split, the exact contents of `sdo` across chained frames, the rejection of 12-bit and 17-bit frames, the narrow-variant masking and the effect of the clear on later frames are end-to-end properties. Only the bench's frame scenarios, checked against its own shift model, can show them.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int WORD_W = 16;
  localparam int CTRL_W = 4;
  localparam int DATA_W = WORD_W - CTRL_W;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cmdrx_shift.sv
module cmdrx_shift
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              cs_n_s,
  output logic [WORD_W-1:0] chain,
  output logic              sdo,
  output logic              cs_rise,
  output logic              cnt_full
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

  logic             sck_d, cs_n_d;
  logic             sck_rise, sck_fall, cs_fall;
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sck_d  <= sck_s;
      cs_n_d <= cs_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
  assign cs_fall  = cs_n_d & ~cs_n_s;
  assign cs_rise  = ~cs_n_d & cs_n_s;
  assign cnt_full = (bit_cnt == CNT_WORD);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chain   <= '0;
      bit_cnt <= '0;
    end else begin
      if (sck_rise) chain <= {chain[WORD_W-2:0], sdi_s};
      if (cs_fall) bit_cnt <= '0;
      else if (sck_rise && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)              sdo <= 1'b0;
    else if (cs_fall || sck_fall) sdo <= chain[WORD_W-1];
  end

  assert_chain_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && !clr) |=> $stable(chain));

  assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(sck_fall) && !$past(cs_fall) && !$past(clr)) |-> $stable(sdo));
endmodule

// File: rtl/cmdrx_commit.sv
module cmdrx_commit
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cs_rise,
  input  logic              cnt_full,
  input  logic [WORD_W-1:0] chain,
  output cmd_word_t         hold,
  output logic              vld,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold <= '0;
      vld  <= 1'b0;
      err  <= 1'b0;
    end else begin
      vld <= cs_rise & cnt_full;
      err <= cs_rise & ~cnt_full;
      if (cs_rise && cnt_full) hold <= cmd_word_t'(chain);
    end
  end

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);

  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(hold));

  assert_hold_only_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!vld && !$past(clr)) |-> $stable(hold));
endmodule

// File: rtl/cmdword_rx.sv
module cmdword_rx
  import cmdrx_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              sdo,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] data,
  output logic              word_vld,
  output logic              frame_err
);
  localparam int PAD = DATA_W - DATA_BITS;

  logic [3:0]        pins_s;
  logic              clr;
  logic [WORD_W-1:0] chain;
  logic              cs_rise, cnt_full;
  cmd_word_t         hold;

  cmdrx_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clr_n, cs_n, sck, sdi}),
    .q   (pins_s)
  );

  assign clr = ~pins_s[3];

  cmdrx_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .sck_s    (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .cs_n_s   (pins_s[2]),
    .chain    (chain),
    .sdo      (sdo),
    .cs_rise  (cs_rise),
    .cnt_full (cnt_full)
  );

  cmdrx_commit u_commit (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .cs_rise  (cs_rise),
    .cnt_full (cnt_full),
    .chain    (chain),
    .hold     (hold),
    .vld      (word_vld),
    .err      (frame_err)
  );

  assign ctrl = hold.ctrl;

  generate
    if (PAD > 0) begin : g_narrow
      assign data = {hold.data[DATA_W-1:PAD], {PAD{1'b0}}};
    end else begin : g_full
      assign data = hold.data;
    end
  endgenerate
endmodule

// File: tb/test_cmdword_rx.sv
`timescale 1ns/1ps
module test_cmdword_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_n = 1'b1, sck = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic        sdo, sdo8, vld, vld8, err, err8;
  logic [3:0]  ctrl, ctrl8;
  logic [11:0] data, data8;

  always #5 clk = ~clk;

  cmdword_rx i_cmdword_rx (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo), .ctrl(ctrl), .data(data), .word_vld(vld), .frame_err(err));

  cmdword_rx #(.DATA_BITS(8)) i_cmdword_rx_n8 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo8), .ctrl(ctrl8), .data(data8), .word_vld(vld8), .frame_err(err8));

  int checks = 0, fails = 0;
  int vld_cnt = 0, err_cnt = 0, cyc = 0;
  logic [15:0] mdl = '0;
  logic [15:0] got_sdo, exp_sdo;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (vld) vld_cnt <= vld_cnt + 1;
    if (err) err_cnt <= err_cnt + 1;
  end

  localparam logic [15:0] VEC [0:5] = '{16'h1ABC, 16'hF00F, 16'h8001,
                                        16'h5A5A, 16'hFFFF, 16'h36C9};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int n, input logic [31:0] bits);
    cs_n = 1'b0;
    got_sdo = '0;
    exp_sdo = '0;
    tick(6);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      tick(6);
      got_sdo = {got_sdo[14:0], sdo};
      exp_sdo = {exp_sdo[14:0], mdl[15]};
      mdl = {mdl[14:0], bits[i]};
      sck = 1'b1;
      tick(6);
      sck = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    tick(8);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R1 ctrl", ctrl, 0);
    check("R1 data", data, 0);
    check("R1 sdo/vld/err", {sdo, vld, err}, 0);

    for (int k = 0; k < 6; k++) begin
      int v0;
      v0 = vld_cnt;
      frame(16, 32'(VEC[k]));
      check("R2 ctrl", ctrl, VEC[k][15:12]);
      check("R2 data", data, VEC[k][11:0]);
      check("R3 one strobe", vld_cnt - v0, 1);
      check("R6 sdo previous word", got_sdo, exp_sdo);
      check("R7 narrow data", data8, {VEC[k][11:4], 4'b0});
    end

    begin : short_frame_R4
      int v0, e0;
      v0 = vld_cnt; e0 = err_cnt;
      frame(12, 32'h0123);
      check("R4 short no strobe", vld_cnt - v0, 0);
      check("R4 short err", err_cnt - e0, 1);
      check("R4 short keeps word", {ctrl, data}, VEC[5]);
      v0 = vld_cnt; e0 = err_cnt;
      frame(17, 32'h1_2345);
      check("R4 long no strobe", vld_cnt - v0, 0);
      check("R4 long err", err_cnt - e0, 1);
      check("R4 long keeps word", {ctrl, data}, VEC[5]);
    end

    begin : idle_sck_R5
      int v0;
      for (int i = 0; i < 10; i++) begin
        sdi = i[0];
        sck = 1'b1; tick(6);
        sck = 1'b0; tick(6);
      end
      check("R5 outputs unchanged", {ctrl, data}, VEC[5]);
      v0 = vld_cnt;
      frame(16, 32'hC3A5);
      check("R5 chain untouched (sdo)", got_sdo, exp_sdo);
      check("R5 word after idle", {ctrl, data}, 16'hC3A5);
      check("R3 strobe after idle", vld_cnt - v0, 1);
    end

    begin : clear_R8
      clr_n = 1'b0;
      tick(6);
      clr_n = 1'b1;
      tick(4);
      mdl = '0;
      check("R8 clear ctrl/data", {ctrl, data}, 0);
      check("R8 clear sdo", sdo, 0);
      frame(16, 32'h9E17);
      check("R8 sdo zeros after clear", got_sdo, 16'h0000);
      check("R9 word after clear", {ctrl, data}, 16'h9E17);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule